// File: doc/BRIEF.md
# Cache Line Idle-Decay Leakage Controller

This block watches every line of a cache and powers down the lines that have gone unused for a while. Each line has a small idle counter. After the counter reaches a configured limit, the line is taken out of full power. The controller supports two low-power policies. In the retention policy, the line keeps its contents in a drowsy state, and the next access wakes it at the cost of a short stall. In the lossy policy, the line is switched off. If the line holds modified data, it first asks for a write-back through a request/acknowledge handshake.

Idle time is measured in one of two ways. The first counts pulses of a coarse global tick. The second counts distinct references to other lines. Lines brought in by a prefetch can use a different limit from lines brought in on demand. The tag of a switched-off line is kept, so the block can flag an access that would have hit if the line had stayed powered. The tag and data arrays and the supply switches are outside the block. They consume the per-line power-state vector.

Top module: `lineDecayTop`

## Requirements
- R1: After reset, every line reads OFF (state code 2'b00, line i at bits [2i+1:2i] of lineState), and stall, wbReq, wakeEvt and lostEvt are low.
- R2: An access is accepted when accValid is high while stall is low. An accepted access puts the addressed line into ACTIVE (2'b01) at the next clock edge and clears its idle counter. A write access (accWrite=1) marks the line dirty.
- R3: In tick mode (cfgCountRefs=0), each tick pulse advances the idle counter of every ACTIVE line that is not accessed in the same cycle. A line decays on the tick that brings its count to its limit, and a limit of 0 behaves as 1. An access in the same cycle as a tick keeps that line ACTIVE.
- R4: In retention mode (cfgLossy=0), a decaying line enters DROWSY (2'b10).
- R5: An accepted access to a DROWSY line returns it to ACTIVE and pulses wakeEvt for one cycle in the next cycle. stall is high for max(cfgWakeCycles,1) cycles starting in the next cycle. While stall is high, accValid has no effect.
- R6: In lossy mode (cfgLossy=1), a clean decaying line goes OFF. A later access to an OFF line that has held data pulses lostEvt in the next cycle. A line never filled since reset does not pulse lostEvt.
- R7: In lossy mode, a dirty decaying line enters WBWAIT (2'b11) and raises wbReq, and wbIdx names the lowest-numbered waiting line. wbAck while wbReq is high turns that line OFF and clean.
- R8: If wbAck and a read access hit the same waiting line in the same cycle, the line becomes ACTIVE and clean, so its next lossy decay raises no write-back.
- R9: In reference mode (cfgCountRefs=1), ticks are ignored. Each accepted access whose index differs from the previously accepted index advances the counter of every other ACTIVE line.
- R10: A line whose last access had accPrefetch=1 decays against cfgPrefLimit. A line whose last access had accPrefetch=0 decays against cfgDemandLimit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accValid | input | 1 | Access strobe |
| accIdx | input | IDX_W | Line index of the access |
| accPrefetch | input | 1 | Access is a prefetch fill |
| accWrite | input | 1 | Access modifies the line |
| tick | input | 1 | Coarse global idle tick |
| cfgLossy | input | 1 | 1 = switch off (lossy), 0 = drowsy (retention) |
| cfgCountRefs | input | 1 | 1 = count other-line references instead of ticks |
| cfgDemandLimit | input | CNT_W | Idle limit for demand lines |
| cfgPrefLimit | input | CNT_W | Idle limit for prefetched lines |
| cfgWakeCycles | input | WAKE_W | Wakeup stall length (0 acts as 1) |
| lineState | output | 2*NUM_LINES | Per-line power state |
| stall | output | 1 | Wakeup in progress, accesses held off |
| wakeEvt | output | 1 | Pulse: a drowsy line was woken |
| lostEvt | output | 1 | Pulse: access would have hit a switched-off line |
| wbReq | output | 1 | Write-back requested |
| wbIdx | output | IDX_W | Line to write back |
| wbAck | input | 1 | Write-back accepted |

## Verification
Two functions can act on one line in the same cycle. A decay tick can coincide with an access to that line, and a write-back acknowledge can coincide with a read access to the waiting line. The bench drives both pairs on the same clock edge. In the first case it judges that the accessed line stays ACTIVE while an untouched neighbour decays. In the second case it judges that the line comes back ACTIVE, and a later lossy decay sends it straight to OFF with no new write-back request, which shows that the acknowledge cleared the dirty mark.

// File: rtl/lineDecayPkg.sv
package lineDecayPkg;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_ACTIVE = 2'd1,
    PS_DROWSY = 2'd2,
    PS_WBWAIT = 2'd3
  } pwrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // access taken this cycle
    logic step;     // idle counters advance this cycle
    logic wbDone;   // pending write-back acknowledged
  } ctrlStrobe_t;

endpackage

// File: rtl/lineDecayCtrl.sv
module lineDecayCtrl
  import lineDecayPkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int WAKE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic              tick,
  input  logic              cfgCountRefs,
  input  logic [WAKE_W-1:0] cfgWakeCycles,
  input  logic              wbAck,
  input  logic              wbPend,
  input  pwrState_e         targetState,
  input  logic              targetTag,
  output ctrlStrobe_t       strobe,
  output logic              stall,
  output logic              wakeEvt,
  output logic              lostEvt
);

  logic [WAKE_W-1:0] wakeCntQ;
  logic [WAKE_W-1:0] wakeLoad;
  logic [IDX_W-1:0]  lastIdxQ;
  logic              lastValidQ;
  logic              accept;
  logic              freshRef;
  logic              wakeHit;
  logic              lostHit;

  assign stall    = (wakeCntQ != '0);
  assign accept   = accValid && !stall;
  assign freshRef = !lastValidQ || (accIdx != lastIdxQ);
  assign wakeHit  = accept && (targetState == PS_DROWSY);
  assign lostHit  = accept && (targetState == PS_OFF) && targetTag;
  assign wakeLoad = (cfgWakeCycles == '0) ? WAKE_W'(1) : cfgWakeCycles;

  always_comb begin
    strobe.accept = accept;
    strobe.step   = cfgCountRefs ? (accept && freshRef) : tick;
    strobe.wbDone = wbAck && wbPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeCntQ   <= '0;
      lastIdxQ   <= '0;
      lastValidQ <= 1'b0;
      wakeEvt    <= 1'b0;
      lostEvt    <= 1'b0;
    end else begin
      wakeEvt <= wakeHit;
      lostEvt <= lostHit;
      if (wakeHit)      wakeCntQ <= wakeLoad;
      else if (stall)   wakeCntQ <= wakeCntQ - 1'b1;
      if (accept) begin
        lastIdxQ   <= accIdx;
        lastValidQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lineDecayDatapath.sv
module lineDecayDatapath
  import lineDecayPkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 2,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [IDX_W-1:0]       accIdx,
  input  logic                   accPrefetch,
  input  logic                   accWrite,
  input  logic                   cfgLossy,
  input  logic [CNT_W-1:0]       cfgDemandLimit,
  input  logic [CNT_W-1:0]       cfgPrefLimit,
  output logic [2*NUM_LINES-1:0] stateVec,
  output pwrState_e              targetState,
  output logic                   targetTag,
  output logic                   wbPend,
  output logic [IDX_W-1:0]       wbSel
);

  logic [NUM_LINES-1:0] tagVec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    pwrState_e        stQ;
    logic [CNT_W-1:0] cntQ;
    logic             dirtyQ;
    logic             prefQ;
    logic             tagQ;
    logic             hitMe;
    logic             ackMe;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cntInc;
    logic             reach;

    assign hitMe  = strobe.accept && (accIdx == IDX_W'(i));
    assign ackMe  = strobe.wbDone && (wbSel == IDX_W'(i));
    assign lim    = prefQ ? cfgPrefLimit : cfgDemandLimit;
    assign cntInc = (cntQ == '1) ? cntQ : cntQ + 1'b1;
    assign reach  = (cntInc >= lim);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ    <= PS_OFF;
        cntQ   <= '0;
        dirtyQ <= 1'b0;
        prefQ  <= 1'b0;
        tagQ   <= 1'b0;
      end else if (hitMe) begin
        stQ    <= PS_ACTIVE;
        cntQ   <= '0;
        prefQ  <= accPrefetch;
        tagQ   <= 1'b1;
        dirtyQ <= accWrite || (dirtyQ && !ackMe);
      end else if (ackMe) begin
        stQ    <= PS_OFF;
        dirtyQ <= 1'b0;
      end else if ((stQ == PS_ACTIVE) && strobe.step) begin
        cntQ <= cntInc;
        if (reach) begin
          if (!cfgLossy)   stQ <= PS_DROWSY;
          else if (dirtyQ) stQ <= PS_WBWAIT;
          else             stQ <= PS_OFF;
        end
      end
    end

    assign stateVec[2*i +: 2] = stQ;
    assign tagVec[i]          = tagQ;
  end

  assign targetState = pwrState_e'(stateVec[{accIdx, 1'b0} +: 2]);
  assign targetTag   = tagVec[accIdx];

  // lowest waiting line wins the write-back port
  always_comb begin
    wbPend = 1'b0;
    wbSel  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (stateVec[2*i +: 2] == PS_WBWAIT) begin
        wbPend = 1'b1;
        wbSel  = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lineDecayTop.sv
module lineDecayTop
  import lineDecayPkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int CNT_W     = 2,
  parameter int WAKE_W    = 3,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accValid,
  input  logic [IDX_W-1:0]       accIdx,
  input  logic                   accPrefetch,
  input  logic                   accWrite,
  input  logic                   tick,
  input  logic                   cfgLossy,
  input  logic                   cfgCountRefs,
  input  logic [CNT_W-1:0]       cfgDemandLimit,
  input  logic [CNT_W-1:0]       cfgPrefLimit,
  input  logic [WAKE_W-1:0]      cfgWakeCycles,
  output logic [2*NUM_LINES-1:0] lineState,
  output logic                   stall,
  output logic                   wakeEvt,
  output logic                   lostEvt,
  output logic                   wbReq,
  output logic [IDX_W-1:0]       wbIdx,
  input  logic                   wbAck
);

  ctrlStrobe_t strobe;
  pwrState_e   targetState;
  logic        targetTag;
  logic        wbPend;

  lineDecayCtrl #(.IDX_W(IDX_W), .WAKE_W(WAKE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIdx(accIdx),
    .tick(tick), .cfgCountRefs(cfgCountRefs), .cfgWakeCycles(cfgWakeCycles),
    .wbAck(wbAck), .wbPend(wbPend), .targetState(targetState),
    .targetTag(targetTag), .strobe(strobe), .stall(stall),
    .wakeEvt(wakeEvt), .lostEvt(lostEvt)
  );

  lineDecayDatapath #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .accIdx(accIdx),
    .accPrefetch(accPrefetch), .accWrite(accWrite), .cfgLossy(cfgLossy),
    .cfgDemandLimit(cfgDemandLimit), .cfgPrefLimit(cfgPrefLimit),
    .stateVec(lineState), .targetState(targetState), .targetTag(targetTag),
    .wbPend(wbPend), .wbSel(wbIdx)
  );

  assign wbReq = wbPend;

endmodule

// File: rtl/lineDecayChk.sv
module lineDecayChk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   accValid,
  input logic                   stall,
  input logic                   wakeEvt,
  input logic                   lostEvt,
  input logic                   wbReq,
  input logic [IDX_W-1:0]       wbIdx,
  input logic                   wbAck,
  input logic [2*NUM_LINES-1:0] lineState
);

  // R5: a wakeup stall only begins together with a wake event
  a_r5_stall_from_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> wakeEvt);

  // R6: a lost-hit pulse needs an accepted access one cycle earlier
  a_r6_lost_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    lostEvt |-> $past(accValid && !stall));

  // R7: the named write-back line really is waiting
  a_r7_wbidx_waiting: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> (lineState[{wbIdx, 1'b0} +: 2] == 2'b11));

  // R7: without ack or access the request does not drop
  a_r7_wbreq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck && !accValid) |=> wbReq);

  // R5: a woken line was drowsy, a lost line was off: never both
  a_r5_evt_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wakeEvt && lostEvt));

endmodule

bind lineDecayTop lineDecayChk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rstN(rstN), .accValid(accValid), .stall(stall),
  .wakeEvt(wakeEvt), .lostEvt(lostEvt), .wbReq(wbReq), .wbIdx(wbIdx),
  .wbAck(wbAck), .lineState(lineState)
);

// File: tb/lineDecayTop_tb_top.sv
`timescale 1ns/1ps
module lineDecayTop_tb_top;

  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           accValid = 1'b0;
  logic [2:0]     accIdx = '0;
  logic           accPrefetch = 1'b0;
  logic           accWrite = 1'b0;
  logic           tick = 1'b0;
  logic           cfgLossy = 1'b0;
  logic           cfgCountRefs = 1'b0;
  logic [1:0]     cfgDemandLimit = 2'd1;
  logic [1:0]     cfgPrefLimit = 2'd1;
  logic [2:0]     cfgWakeCycles = 3'd1;
  logic [2*N-1:0] lineState;
  logic           stall, wakeEvt, lostEvt, wbReq, wbAck = 1'b0;
  logic [2:0]     wbIdx;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  lineDecayTop dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIdx(accIdx),
    .accPrefetch(accPrefetch), .accWrite(accWrite), .tick(tick),
    .cfgLossy(cfgLossy), .cfgCountRefs(cfgCountRefs),
    .cfgDemandLimit(cfgDemandLimit), .cfgPrefLimit(cfgPrefLimit),
    .cfgWakeCycles(cfgWakeCycles), .lineState(lineState), .stall(stall),
    .wakeEvt(wakeEvt), .lostEvt(lostEvt), .wbReq(wbReq), .wbIdx(wbIdx),
    .wbAck(wbAck)
  );

  function automatic int st(int i);
    return int'(lineState[2*i +: 2]);
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic acc(int idx, bit pf, bit wr);
    accValid = 1'b1; accIdx = 3'(idx); accPrefetch = pf; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0; accPrefetch = 1'b0; accWrite = 1'b0;
  endtask

  task automatic tk();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 lineState", int'(lineState), 0);
    chk("R1 stall", int'(stall), 0);
    chk("R1 wbReq", int'(wbReq), 0);
    chk("R1 events", int'(wakeEvt | lostEvt), 0);

    // R2 fills make every line ACTIVE
    for (int i = 0; i < N; i++) begin
      acc(i, 1'b0, 1'b0);
      chk("R2 fill active", st(i), 1);
    end

    // R3/R4 retention decay sweep over demand limit (0 acts as 1)
    for (int lim = 0; lim < 4; lim++) begin
      doReset();
      cfgLossy = 1'b0; cfgDemandLimit = 2'(lim); cfgPrefLimit = 2'd3;
      acc(0, 1'b0, 1'b0);
      for (int t = 1; t <= 3; t++) begin
        tk();
        chk("R3 R4 decay timing", st(0), (t >= ((lim == 0) ? 1 : lim)) ? 2 : 1);
      end
    end

    // R10 prefetch lines use their own limit
    doReset();
    cfgDemandLimit = 2'd1; cfgPrefLimit = 2'd3;
    acc(1, 1'b1, 1'b0);
    acc(2, 1'b0, 1'b0);
    tk();
    chk("R10 demand line drowsy", st(2), 2);
    chk("R10 prefetch line active", st(1), 1);
    tk(); tk();
    chk("R10 prefetch line drowsy at 3", st(1), 2);

    // R3 tick and access to the same line in one cycle
    doReset();
    cfgDemandLimit = 2'd1;
    acc(0, 1'b0, 1'b0);
    acc(1, 1'b0, 1'b0);
    tick = 1'b1;
    acc(1, 1'b0, 1'b0);
    tick = 1'b0;
    chk("R3 accessed line stays active", st(1), 1);
    chk("R3 neighbour decays", st(0), 2);

    // R5 wake stall length sweep
    for (int w = 0; w < 5; w++) begin
      doReset();
      cfgDemandLimit = 2'd1; cfgWakeCycles = 3'(w);
      acc(0, 1'b0, 1'b0);
      tk();
      acc(0, 1'b0, 1'b0);
      chk("R5 wakeEvt", int'(wakeEvt), 1);
      chk("R5 woken active", st(0), 1);
      begin
        int n;
        n = 0;
        while (stall && n < 20) begin
          n++;
          @(negedge clk);
        end
        chk("R5 stall length", n, (w == 0) ? 1 : w);
      end
      chk("R5 wakeEvt one cycle", int'(wakeEvt), 0);
    end

    // R5 access during stall ignored
    doReset();
    cfgWakeCycles = 3'd4;
    acc(0, 1'b0, 1'b0);
    tk();
    acc(0, 1'b0, 1'b0);
    acc(3, 1'b0, 1'b0);
    chk("R5 ignored during stall", st(3), 0);
    repeat (5) @(negedge clk);
    chk("R5 ignored after stall", st(3), 0);

    // R6 lossy clean decay and lost hit
    doReset();
    cfgLossy = 1'b1; cfgDemandLimit = 2'd1;
    acc(6, 1'b0, 1'b0);
    tk();
    chk("R6 clean goes off", st(6), 0);
    chk("R6 no wbReq", int'(wbReq), 0);
    acc(6, 1'b0, 1'b0);
    chk("R6 lostEvt", int'(lostEvt), 1);
    acc(7, 1'b0, 1'b0);
    chk("R6 fresh line no lostEvt", int'(lostEvt), 0);

    // R7 dirty write-back ordering
    doReset();
    cfgLossy = 1'b1; cfgDemandLimit = 2'd1;
    acc(5, 1'b0, 1'b1);
    acc(2, 1'b0, 1'b1);
    tk();
    chk("R7 line2 waiting", st(2), 3);
    chk("R7 line5 waiting", st(5), 3);
    chk("R7 wbReq", int'(wbReq), 1);
    chk("R7 wbIdx lowest", int'(wbIdx), 2);
    wbAck = 1'b1; @(negedge clk); wbAck = 1'b0;
    chk("R7 acked off", st(2), 0);
    chk("R7 next wbIdx", int'(wbIdx), 5);
    wbAck = 1'b1; @(negedge clk); wbAck = 1'b0;
    chk("R7 all done", int'(wbReq), 0);

    // R8 ack and read access on the same line together
    doReset();
    cfgLossy = 1'b1; cfgDemandLimit = 2'd1;
    acc(4, 1'b0, 1'b1);
    tk();
    chk("R8 waiting", st(4), 3);
    wbAck = 1'b1;
    acc(4, 1'b0, 1'b0);
    wbAck = 1'b0;
    chk("R8 active after clash", st(4), 1);
    chk("R8 request gone", int'(wbReq), 0);
    tk();
    chk("R8 clean decay off", st(4), 0);
    chk("R8 no new write-back", int'(wbReq), 0);

    // R9 reference counting mode
    doReset();
    cfgLossy = 1'b0; cfgCountRefs = 1'b1; cfgDemandLimit = 2'd2;
    acc(0, 1'b0, 1'b0);
    repeat (5) tk();
    chk("R9 ticks ignored", st(0), 1);
    acc(1, 1'b0, 1'b0);
    acc(1, 1'b0, 1'b0);
    chk("R9 repeat counted once", st(0), 1);
    acc(2, 1'b0, 1'b0);
    chk("R9 second distinct ref decays", st(0), 2);
    chk("R9 line1 still active", st(1), 1);
    cfgCountRefs = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule